// File: doc/BRIEF.md
# Fast Loadable Down Counter

This block is a synchronous down counter meant for designs clocked near the limit of the fabric. The counter can be loaded with a start value. It steps down by one on every clock in which its enable input is high. It raises a terminal-count flag when the count runs out. Every output is driven directly from a flip-flop, and the design keeps wide logic off the critical path in two ways.

The count is stored as two segments, a low one and a high one. The high segment takes its borrow from a registered "low segment is zero" flag rather than from a carry chain that runs the full width. Each segment also keeps registered predictions of "equals zero" and "equals one". The terminal flag is therefore set one cycle ahead, from those predictions, and no full-width compare is needed.

A parameter selects one of two flag modes:
- **Predicted-zero mode.** The flag is high exactly while the count is zero.
- **Underflow mode.** The flag is a one-cycle pulse one clock after a decrement carries the most significant bit from 0 to 1. This mode has no zero decode at all.

Top module: `dncnt_fast`

## Requirements
- R1: Reset is synchronous and active high, and it overrides load and enable. One clock after reset, the count is 0. The flag is then 1 in predicted-zero mode and 0 in underflow mode.
- R2: Load takes priority over enable. One clock after `ld` is high, `count` equals the value that was on `ld_val`.
- R3: When `ld` is low and `en` is high, the count drops by exactly one per clock. When both are low, the count holds its value.
- R4: In predicted-zero mode, `tc` is 1 in exactly the cycles in which `count` is 0, including cycles in which the count is held at zero.
- R5: In predicted-zero mode, loading 0 sets `tc` on the next cycle, and loading any nonzero value clears it.
- R6: A decrement from 0 wraps the count to all ones and clears `tc`.
- R7: The count is exact in every cycle, including when the low segment wraps. For example, with a 32-bit count and a 16-bit low segment, 0x0001_0000 steps to 0x0000_FFFF.
- R8: In underflow mode, `tc` is high for exactly one cycle. That cycle comes one clock after a decrement turns the most significant bit of `count` from 0 to 1. A load that sets that bit does not raise `tc`.
- R9: The count width and the low-segment width are parameters. The same RTL works at a width of 20 and at a width of 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ld | input | 1 | Load strobe |
| ld_val | input | WIDTH | Value to load |
| en | input | 1 | Count enable; acts as a clock enable on the count |
| count | output | WIDTH | Current count, registered |
| tc | output | 1 | Terminal-count flag, registered |

## Verification
The assertions assume that `rst`, `ld`, `en` and `ld_val` are synchronous to `clk` and hold a known 0 or 1 at each rising edge. The cycle checks on the flag assume that reset has been released for at least one edge. The bench drives every input one nanosecond after a rising edge, so inputs stay stable across the next edge. It holds reset for two clocks before any other stimulus. It never applies a load and reset together, except in the one directed test of reset priority.

// File: rtl/dncnt_pkg.sv
`timescale 1ns/1ps
package dncnt_pkg;
  // Terminal-count flag flavours
  typedef enum logic [0:0] {
    TC_PREDICT_ZERO = 1'b0, // flag high exactly while count is zero
    TC_UNDERFLOW    = 1'b1  // one-cycle pulse after MSB rises by decrement
  } tc_mode_e;
endpackage

// File: rtl/dncnt_seg.sv
`timescale 1ns/1ps
// One segment of the split counter with registered zero/one predictions.
module dncnt_seg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic [W-1:0] ld_val,
  input  logic         dec,
  output logic [W-1:0] cnt,
  output logic         is_zero,
  output logic         is_one
);
  localparam logic [W-1:0] ONE = W'(1);
  localparam logic [W-1:0] TWO = W'(2);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      is_zero <= 1'b1;
      is_one  <= 1'b0;
    end else if (ld) begin
      cnt     <= ld_val;
      is_zero <= (ld_val == '0);
      is_one  <= (ld_val == ONE);
    end else if (dec) begin
      cnt     <= cnt - ONE;
      is_zero <= is_one;          // one becomes zero
      is_one  <= (cnt == TWO);    // segment-local compare only
    end
  end

  // R4: zero prediction agrees with the stored segment value
  assert_seg_zero_R4: assert property (@(posedge clk) disable iff (rst)
    is_zero == (cnt == '0));
  // R3: segment holds when neither load nor decrement
  assert_seg_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!ld && !dec) |=> $stable(cnt));
  // R6: wrap from zero goes to all ones
  assert_seg_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    (!ld && dec && cnt == '0) |=> (cnt == '1));
endmodule

// File: rtl/dncnt_zflag.sv
`timescale 1ns/1ps
// Predicted zero flag: set on the cycle the count leaves one by decrement.
module dncnt_zflag (
  input  logic clk,
  input  logic rst,
  input  logic ld,
  input  logic ld_zero,
  input  logic en,
  input  logic one_now,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (rst)      flag <= 1'b1;
    else if (ld)  flag <= ld_zero;
    else if (en)  flag <= one_now;
  end

  // R4: flag holds while the count is not stepping
  assert_zflag_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!ld && !en) |=> $stable(flag));
endmodule

// File: rtl/dncnt_uflow.sv
`timescale 1ns/1ps
// Underflow detector: MSB rising edge caused by a decrement, one cycle late.
module dncnt_uflow (
  input  logic clk,
  input  logic rst,
  input  logic ld,
  input  logic en,
  input  logic msb,
  output logic pulse
);
  logic step_q;   // the edge that produced the current count was a decrement
  logic prev_q;   // MSB of the count before that edge

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q <= 1'b0;
      prev_q <= 1'b0;
      pulse  <= 1'b0;
    end else begin
      step_q <= en & ~ld;
      prev_q <= msb;
      pulse  <= step_q & msb & ~prev_q;
    end
  end

  // R8: pulse lasts a single cycle
  assert_uf_single_R8: assert property (@(posedge clk) disable iff (rst)
    pulse |=> !pulse);
  // R8: pulse follows a 0 -> 1 MSB transition one cycle earlier
  assert_uf_edge_R8: assert property (@(posedge clk) disable iff (rst)
    pulse |-> ($past(msb) && !$past(msb, 2)));
endmodule

// File: rtl/dncnt_fast.sv
`timescale 1ns/1ps
// Split down counter with registered borrow and registered terminal flag.
module dncnt_fast #(
  parameter int                  WIDTH = 32,
  parameter int                  LO_W  = WIDTH / 2,
  parameter dncnt_pkg::tc_mode_e MODE  = dncnt_pkg::TC_PREDICT_ZERO
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ld,
  input  logic [WIDTH-1:0] ld_val,
  input  logic             en,
  output logic [WIDTH-1:0] count,
  output logic             tc
);
  localparam int HI_W = WIDTH - LO_W;

  logic [LO_W-1:0] lo_cnt;
  logic [HI_W-1:0] hi_cnt;
  logic            lo_z, lo_o, hi_z, hi_o;
  logic            hi_dec;

  // Borrow into the high half comes from a registered zero flag of the low half.
  assign hi_dec = en & lo_z;

  dncnt_seg #(.W(LO_W)) u_lo (
    .clk(clk), .rst(rst), .ld(ld), .ld_val(ld_val[LO_W-1:0]), .dec(en),
    .cnt(lo_cnt), .is_zero(lo_z), .is_one(lo_o));

  dncnt_seg #(.W(HI_W)) u_hi (
    .clk(clk), .rst(rst), .ld(ld), .ld_val(ld_val[WIDTH-1:LO_W]), .dec(hi_dec),
    .cnt(hi_cnt), .is_zero(hi_z), .is_one(hi_o));

  assign count = {hi_cnt, lo_cnt};

  generate
    if (MODE == dncnt_pkg::TC_PREDICT_ZERO) begin : g_zero
      logic zf;
      dncnt_zflag u_zf (
        .clk(clk), .rst(rst), .ld(ld), .ld_zero(ld_val == '0), .en(en),
        .one_now(lo_o & hi_z), .flag(zf));
      assign tc = zf;

      // R4: flag marks exactly the zero count
      assert_tc_zero_R4: assert property (@(posedge clk) disable iff (rst)
        tc == (count == '0));
      // R5: load decides the flag on the next cycle
      assert_tc_load_R5: assert property (@(posedge clk) disable iff (rst)
        ld |=> (tc == ($past(ld_val) == '0)));
      // R6: leaving zero by decrement clears the flag
      assert_tc_wrap_R6: assert property (@(posedge clk) disable iff (rst)
        (!ld && en && tc) |=> !tc);
    end else begin : g_uflow
      logic uf;
      dncnt_uflow u_uf (
        .clk(clk), .rst(rst), .ld(ld), .en(en), .msb(count[WIDTH-1]),
        .pulse(uf));
      assign tc = uf;
    end
  endgenerate

  // R1: reset clears the count on the following cycle
  assert_reset_R1: assert property (@(posedge clk)
    $past(rst) |-> (count == '0));
  // R2: load wins over enable
  assert_load_R2: assert property (@(posedge clk) disable iff (rst)
    ld |=> (count == $past(ld_val)));
  // R3 / R7: enabled step is exact across the segment boundary
  assert_step_R7: assert property (@(posedge clk) disable iff (rst)
    (!ld && en) |=> (count == $past(count) - WIDTH'(1)));
  // R3: count holds with enable low
  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (!ld && !en) |=> $stable(count));
  // R7: high half one and zero predictions never overlap
  assert_hi_pred_R7: assert property (@(posedge clk) disable iff (rst)
    hi_o |-> !hi_z);
endmodule

// File: tb/sim_dncnt_fast.sv
`timescale 1ns/1ps
module sim_dncnt_fast;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst, ld0, en0, ld1, en1;
  logic [31:0] v0;
  logic [19:0] v1;
  logic [31:0] c0;
  logic [19:0] c1;
  logic        t0, t1;
  int checks = 0;
  int fails  = 0;

  dncnt_fast #(.WIDTH(32), .LO_W(16), .MODE(dncnt_pkg::TC_PREDICT_ZERO)) u0 (
    .clk(clk), .rst(rst), .ld(ld0), .ld_val(v0), .en(en0), .count(c0), .tc(t0));
  dncnt_fast #(.WIDTH(20), .LO_W(10), .MODE(dncnt_pkg::TC_UNDERFLOW)) u1 (
    .clk(clk), .rst(rst), .ld(ld1), .ld_val(v1), .en(en1), .count(c1), .tc(t1));

  // {ld, en, ld_val, expected count, expected tc}; covers R2 R3 R4 R5 R6 R7
  localparam int N = 19;
  localparam logic [66:0] VEC [N] = '{
    {1'b1, 1'b1, 32'h3,        32'h3,        1'b0}, // R2 load beats enable
    {1'b0, 1'b1, 32'h0,        32'h2,        1'b0}, // R3
    {1'b0, 1'b0, 32'h0,        32'h2,        1'b0}, // R3 hold
    {1'b0, 1'b1, 32'h0,        32'h1,        1'b0},
    {1'b0, 1'b1, 32'h0,        32'h0,        1'b1}, // R4
    {1'b0, 1'b0, 32'h0,        32'h0,        1'b1}, // R4 held at zero
    {1'b0, 1'b1, 32'h0,        32'hFFFFFFFF, 1'b0}, // R6 wrap
    {1'b1, 1'b0, 32'h00010000, 32'h00010000, 1'b0},
    {1'b0, 1'b1, 32'h0,        32'h0000FFFF, 1'b0}, // R7 boundary
    {1'b0, 1'b1, 32'h0,        32'h0000FFFE, 1'b0},
    {1'b1, 1'b0, 32'h0,        32'h0,        1'b1}, // R5 load zero
    {1'b1, 1'b1, 32'h5,        32'h5,        1'b0}, // R5 load nonzero
    {1'b1, 1'b0, 32'h00010001, 32'h00010001, 1'b0},
    {1'b0, 1'b1, 32'h0,        32'h00010000, 1'b0},
    {1'b0, 1'b1, 32'h0,        32'h0000FFFF, 1'b0}, // R7
    {1'b1, 1'b0, 32'h1,        32'h1,        1'b0},
    {1'b0, 1'b1, 32'h0,        32'h0,        1'b1}, // R4
    {1'b1, 1'b1, 32'h00020000, 32'h00020000, 1'b0},
    {1'b0, 1'b1, 32'h0,        32'h0001FFFF, 1'b0}  // R7
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    rst = 1'b1; ld0 = 1'b0; en0 = 1'b0; v0 = '0;
    ld1 = 1'b0; en1 = 1'b0; v1 = '0;
    tick(); tick();
    rst = 1'b0;
    chk("R1 count after reset", c0, 32'h0);
    chk("R1 flag after reset zero mode", {31'b0, t0}, 32'h1);
    chk("R1 flag after reset underflow mode", {31'b0, t1}, 32'h0);

    for (int i = 0; i < N; i++) begin
      {ld0, en0, v0} = VEC[i][66:33];
      tick();
      chk($sformatf("R3 table count step %0d", i), c0, VEC[i][32:1]);
      chk($sformatf("R4 table flag step %0d", i), {31'b0, t0}, {31'b0, VEC[i][0]});
    end
    ld0 = 1'b0; en0 = 1'b0;

    // R1: reset overrides load and enable
    ld0 = 1'b1; en0 = 1'b1; v0 = 32'h7; rst = 1'b1;
    tick();
    rst = 1'b0; ld0 = 1'b0; en0 = 1'b0;
    chk("R1 reset priority count", c0, 32'h0);
    chk("R1 reset priority flag", {31'b0, t0}, 32'h1);

    // R8 / R9: underflow pulse timing on the 20-bit instance
    ld1 = 1'b1; v1 = 20'h2; tick();
    ld1 = 1'b0; en1 = 1'b1;
    tick(); chk("R9 u1 count 1", {12'b0, c1}, 32'h1);
    tick(); chk("R8 no pulse at zero", {31'b0, t1}, 32'h0);
    tick(); chk("R6 u1 wrap", {12'b0, c1}, 32'hFFFFF);
    chk("R8 no pulse in wrap cycle", {31'b0, t1}, 32'h0);
    tick(); chk("R8 pulse one cycle late", {31'b0, t1}, 32'h1);
    chk("R3 u1 count keeps stepping", {12'b0, c1}, 32'hFFFFE);
    tick(); chk("R8 pulse single cycle", {31'b0, t1}, 32'h0);
    en1 = 1'b0;

    // R8: load setting MSB does not pulse
    ld1 = 1'b1; v1 = 20'h0; tick();
    v1 = 20'h80000; tick();
    ld1 = 1'b0;
    chk("R2 u1 load msb value", {12'b0, c1}, 32'h80000);
    tick(); chk("R8 load no pulse a", {31'b0, t1}, 32'h0);
    tick(); chk("R8 load no pulse b", {31'b0, t1}, 32'h0);

    // R7 / R9: segment boundary at 20 bits
    ld1 = 1'b1; v1 = 20'h00400; tick();
    ld1 = 1'b0; en1 = 1'b1;
    tick(); chk("R7 u1 boundary", {12'b0, c1}, 32'h003FF);
    tick(); chk("R9 u1 after boundary", {12'b0, c1}, 32'h003FE);
    en1 = 1'b0;
    tick(); chk("R3 u1 hold", {12'b0, c1}, 32'h003FE);

    summary();
    $finish;
  end
endmodule